// File: doc/BRIEF.md
# Leakage-Guided Retention Error Recovery Unit

This unit repairs the two-bit contents of a multi-level flash page whose read has already failed with more errors than the error-correcting code can handle. Every cell of the page is presented once, as a pair of threshold-voltage samples. The first sample is taken when the failure is found. The second is taken after the page has been left alone for a further retention interval. Firmware supplies the three read references, the voltage boundary between the two highest programmed states, a margin of one distribution sigma around that boundary, and a voltage-drop threshold. These values are captured when a job starts.

A cell whose first sample lies outside the margin window is decoded in the usual way, by comparing it against the three references. A cell inside the window is treated as risky, and its state is inferred from how fast it leaks. Charge is lost faster from cells that started in the higher state. A risky cell whose voltage fell by at least the threshold between the two samples is therefore given the higher state. A risky cell that fell by less is given the lower of the two. Corrected codes stream out one cycle after each cell is accepted. Each code carries a flag that shows whether the recovery overrode the plain decode. The repaired page then goes to the ECC decoder.

Control is a two-state machine. ST_IDLE waits for a job. The transition ST_IDLE→ST_RUN happens when `start` is seen with a nonzero cell count; this captures the configuration and the count. ST_RUN accepts one cell on each cycle that `in_valid` is high. The transition ST_RUN→ST_IDLE happens when the cell that uses up the count is accepted.

Top module: `leak_recover`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `busy`, `out_valid`, `out_fixed` and `out_last` are all 0.
- R2: In ST_IDLE, `start` with `cell_count` nonzero raises `busy` after the next clock edge. `start` with `cell_count` equal to 0 leaves `busy` at 0.
- R3: A cell offered while `busy` is 0 is ignored and produces no `out_valid`.
- R4: Each cell accepted in ST_RUN produces exactly one `out_valid` pulse on the following cycle, and the outputs keep the order in which cells were accepted.
- R5: A non-risky cell is decoded from its first sample v as follows, with codes 11 = erased, 10 = P1, 00 = P2 and 01 = P3. If v < ref_a the code is 11. If ref_a ≤ v < ref_b the code is 10. If ref_b ≤ v < ref_c the code is 00. If v ≥ ref_c the code is 01.
- R6: A cell is risky when boundary − sigma ≤ v ≤ boundary + sigma, with both ends inclusive. The window is computed without wraparound: it is clipped at 0 below and extended past the top code above.
- R7: A risky cell has drop = first − second, or 0 when the second sample is higher than the first. The cell gets code 01 when drop ≥ drop_thr, and code 00 otherwise.
- R8: `out_fixed` is 1 exactly when the emitted code differs from the R5 decode of the same first sample.
- R9: Configuration and count are captured only at the ST_IDLE→ST_RUN transition. Changes to these inputs during ST_RUN have no effect on that job.
- R10: `start` during ST_RUN is ignored: the job still ends after its captured count.
- R11: `out_last` is 1 on the output of the job's final cell, and `busy` is 0 from the same cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (sampled in ST_IDLE only) |
| cell_count | input | CW | Number of cells in the job |
| ref_a | input | VW | Lowest read reference |
| ref_b | input | VW | Middle read reference |
| ref_c | input | VW | Highest read reference |
| bound | input | VW | Boundary voltage between the two top states |
| sigma | input | VW | Half-width of the risky window |
| drop_thr | input | VW | Minimum drop that marks a fast-leaking cell |
| in_valid | input | 1 | A cell pair is present |
| v_first | input | VW | Sample taken when the failure is found |
| v_second | input | VW | Sample taken after the extra retention wait |
| busy | output | 1 | High in ST_RUN |
| out_valid | output | 1 | Corrected code present |
| out_code | output | 2 | Corrected two-bit code |
| out_fixed | output | 1 | Recovery overrode the plain decode |
| out_last | output | 1 | Output of the job's final cell |

## Verification
The checker assumes the references are ascending. It also assumes that `in_valid` is only meaningful while `busy` is high: a cell offered in ST_IDLE must not appear at the output. Because the flag can only be set inside the risky window, the checker assumes that a flagged output always carries one of the two top-state codes. The stimulus draws ascending references, and it places the boundary at or near the top reference so that the flag rule stays consistent. It draws many first samples inside the window and near its edges, and it deliberately offers cells and start pulses while idle and in the middle of a job.

// File: rtl/lr_pkg.sv
package lr_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } lr_state_e;

    localparam logic [1:0] CODE_ERASED = 2'b11;
    localparam logic [1:0] CODE_P1     = 2'b10;
    localparam logic [1:0] CODE_P2     = 2'b00;
    localparam logic [1:0] CODE_P3     = 2'b01;

endpackage

// File: rtl/lr_hard_decode.sv
module lr_hard_decode #(
    parameter int VW = 10
) (
    input  logic [VW-1:0] v,
    input  logic [VW-1:0] ref_a,
    input  logic [VW-1:0] ref_b,
    input  logic [VW-1:0] ref_c,
    output logic [1:0]    code
);
    import lr_pkg::*;

    logic [2:0] above;

    // thermometer of reference crossings
    assign above[0] = (v >= ref_a);
    assign above[1] = (v >= ref_b);
    assign above[2] = (v >= ref_c);

    always_comb begin
        if (above[2])      code = CODE_P3;
        else if (above[1]) code = CODE_P2;
        else if (above[0]) code = CODE_P1;
        else               code = CODE_ERASED;
    end
endmodule

// File: rtl/lr_risk_judge.sv
module lr_risk_judge #(
    parameter int VW = 10
) (
    input  logic [VW-1:0] v_first,
    input  logic [VW-1:0] v_second,
    input  logic [VW-1:0] bound,
    input  logic [VW-1:0] sigma,
    input  logic [VW-1:0] drop_thr,
    output logic          risky,
    output logic          fast
);
    localparam int XW = VW + 1;

    logic [XW-1:0] win_lo;
    logic [XW-1:0] win_hi;
    logic [XW-1:0] v_ext;
    logic [VW-1:0] drop;

    assign v_ext  = {1'b0, v_first};
    // window ends computed one bit wider: clip below, no wrap above
    assign win_lo = (sigma > bound) ? '0 : {1'b0, bound - sigma};
    assign win_hi = {1'b0, bound} + {1'b0, sigma};

    assign risky = (v_ext >= win_lo) && (v_ext <= win_hi);

    assign drop = (v_first > v_second) ? (v_first - v_second) : '0;
    assign fast = (drop >= drop_thr);
endmodule

// File: rtl/lr_ctrl.sv
module lr_ctrl #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] cell_count,
    input  logic          in_valid,
    output logic          launch,
    output logic          accept,
    output logic          final_cell,
    output logic          busy
);
    import lr_pkg::*;

    lr_state_e     state_q, state_d;
    logic [CW-1:0] left_q,  left_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        left_d     = left_q;
        launch     = 1'b0;
        accept     = 1'b0;
        final_cell = 1'b0;
        busy       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start && (cell_count != '0)) begin
                    launch  = 1'b1;
                    left_d  = cell_count;
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                busy = 1'b1;
                if (in_valid) begin
                    accept = 1'b1;
                    left_d = left_q - 1'b1;
                    if (left_q == {{(CW-1){1'b0}}, 1'b1}) begin
                        final_cell = 1'b1;
                        state_d    = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/leak_recover.sv
module leak_recover #(
    parameter int VW = 10,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] cell_count,
    input  logic [VW-1:0] ref_a,
    input  logic [VW-1:0] ref_b,
    input  logic [VW-1:0] ref_c,
    input  logic [VW-1:0] bound,
    input  logic [VW-1:0] sigma,
    input  logic [VW-1:0] drop_thr,
    input  logic          in_valid,
    input  logic [VW-1:0] v_first,
    input  logic [VW-1:0] v_second,
    output logic          busy,
    output logic          out_valid,
    output logic [1:0]    out_code,
    output logic          out_fixed,
    output logic          out_last
);
    import lr_pkg::*;

    logic          launch, accept, final_cell;
    logic [VW-1:0] ra_q, rb_q, rc_q, bd_q, sg_q, th_q;
    logic [1:0]    hard_code, fixed_code;
    logic          risky, fast;

    lr_ctrl #(.CW(CW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cell_count (cell_count),
        .in_valid   (in_valid),
        .launch     (launch),
        .accept     (accept),
        .final_cell (final_cell),
        .busy       (busy)
    );

    // configuration captured at job launch only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ra_q <= '0; rb_q <= '0; rc_q <= '0;
            bd_q <= '0; sg_q <= '0; th_q <= '0;
        end else if (launch) begin
            ra_q <= ref_a; rb_q <= ref_b; rc_q <= ref_c;
            bd_q <= bound; sg_q <= sigma; th_q <= drop_thr;
        end
    end

    lr_hard_decode #(.VW(VW)) u_hard (
        .v     (v_first),
        .ref_a (ra_q),
        .ref_b (rb_q),
        .ref_c (rc_q),
        .code  (hard_code)
    );

    lr_risk_judge #(.VW(VW)) u_judge (
        .v_first  (v_first),
        .v_second (v_second),
        .bound    (bd_q),
        .sigma    (sg_q),
        .drop_thr (th_q),
        .risky    (risky),
        .fast     (fast)
    );

    always_comb begin
        if (risky) fixed_code = fast ? CODE_P3 : CODE_P2;
        else       fixed_code = hard_code;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= CODE_P2;
            out_fixed <= 1'b0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= accept;
            out_last  <= final_cell;
            if (accept) begin
                out_code  <= fixed_code;
                out_fixed <= (fixed_code != hard_code);
            end else begin
                out_fixed <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lr_checker.sv
module lr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       in_valid,
    input logic       busy,
    input logic       out_valid,
    input logic [1:0] out_code,
    input logic       out_fixed,
    input logic       out_last
);
    // R3 R4: outputs only follow a cell accepted while busy
    assert_out_needs_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(busy) && $past(in_valid)));

    // R8: a flagged cell always carries one of the two top-state codes
    assert_fix_top_states_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_fixed |-> (out_valid && out_code[1] == 1'b0));

    // R11: busy ends together with the last output
    assert_last_ends_job_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (out_valid && out_last));

    // R2: without start, idle stays idle
    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);

    // R11: last flag only on a valid output
    assert_last_is_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
endmodule

bind leak_recover lr_checker u_lr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_valid  (in_valid),
    .busy      (busy),
    .out_valid (out_valid),
    .out_code  (out_code),
    .out_fixed (out_fixed),
    .out_last  (out_last)
);

// File: tb/tb_leak_recover.sv
module tb_leak_recover;
    localparam int VW = 10;
    localparam int CW = 16;
    localparam int VMAX = (1 << VW) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [CW-1:0] cell_count;
    logic [VW-1:0] ref_a, ref_b, ref_c, bound, sigma, drop_thr;
    logic          in_valid;
    logic [VW-1:0] v_first, v_second;
    logic          busy, out_valid, out_fixed, out_last;
    logic [1:0]    out_code;

    int n_chk = 0;
    int n_bad = 0;
    int ca, cb, cc, cbd, csg, cth, left;

    always #4 clk = ~clk;

    leak_recover #(.VW(VW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cell_count(cell_count),
        .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c), .bound(bound),
        .sigma(sigma), .drop_thr(drop_thr), .in_valid(in_valid),
        .v_first(v_first), .v_second(v_second), .busy(busy),
        .out_valid(out_valid), .out_code(out_code), .out_fixed(out_fixed),
        .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] plain(input int v);
        if (v >= cc) return 2'b01;
        if (v >= cb) return 2'b00;
        if (v >= ca) return 2'b10;
        return 2'b11;
    endfunction

    function automatic logic [1:0] model(input int v1, input int v2);
        int d;
        if (v1 < cbd - csg || v1 > cbd + csg) return plain(v1);
        d = (v2 > v1) ? 0 : v1 - v2;
        return (d >= cth) ? 2'b01 : 2'b00;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_cfg(input int a, input int b, input int c, input int bd,
                           input int s, input int t);
        ref_a = a[VW-1:0]; ref_b = b[VW-1:0]; ref_c = c[VW-1:0];
        bound = bd[VW-1:0]; sigma = s[VW-1:0]; drop_thr = t[VW-1:0];
    endtask

    task automatic launch(input int n);
        start = 1'b1; cell_count = n[CW-1:0];
        ca = ref_a; cb = ref_b; cc = ref_c; cbd = bound; csg = sigma; cth = drop_thr;
        left = n;
        step();
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
    endtask

    task automatic send(input int v1, input int v2, input int gap);
        logic [1:0] e;
        e = model(v1, v2);
        in_valid = 1'b1; v_first = v1[VW-1:0]; v_second = v2[VW-1:0];
        step();
        in_valid = 1'b0;
        left--;
        chk(out_valid == 1'b1, "R4 out_valid", out_valid, 1);
        chk(out_code == e, "R5/R6/R7 code", out_code, e);
        chk(out_fixed == (e != plain(v1)), "R8 fixed flag", out_fixed, e != plain(v1));
        chk(out_last == (left == 0), "R11 last flag", out_last, left == 0);
        chk(busy == (left != 0), "R11 busy", busy, left != 0);
        for (int g = 0; g < gap; g++) begin
            step();
            chk(out_valid == 1'b0, "R4 single pulse", out_valid, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int x;
        void'($urandom(1234));
        rst_n = 1'b0; start = 1'b0; cell_count = '0; in_valid = 1'b0;
        v_first = '0; v_second = '0;
        set_cfg(200, 400, 600, 600, 50, 20);
        repeat (3) step();
        chk(busy == 0 && out_valid == 0 && out_fixed == 0 && out_last == 0,
            "R1 reset outputs", busy, 0);
        rst_n = 1'b1;
        step();
        chk(busy == 0 && out_valid == 0, "R1 after release", out_valid, 0);

        // R3: cell while idle
        in_valid = 1'b1; v_first = 10'd650; v_second = 10'd600;
        step(); in_valid = 1'b0;
        step();
        chk(out_valid == 0, "R3 idle cell ignored", out_valid, 0);

        // R2: zero count
        start = 1'b1; cell_count = '0;
        step(); start = 1'b0;
        chk(busy == 0, "R2 zero count", busy, 1'b0);

        // directed job
        launch(11);
        // R9: change live configuration, R10: start mid-job
        set_cfg(10, 20, 30, 900, 5, 500);
        start = 1'b1; cell_count = 16'd3;
        send(100, 100, 0);   // R5 erased
        start = 1'b0;
        send(300, 290, 1);   // R5 P1
        send(500, 400, 0);   // R5 P2
        send(700, 600, 0);   // R5 P3
        send(550, 530, 0);   // R6 low edge, R7 fast -> fixed
        send(650, 631, 2);   // R6 high edge, R7 slow -> fixed
        send(549, 400, 0);   // R6 just outside
        send(651, 651, 0);   // R6 just outside
        send(600, 610, 0);   // R7 negative drop -> slow
        send(600, 570, 0);   // R7 fast, not fixed
        send(551, 531, 0);   // last
        step();
        chk(busy == 0, "R10 start during run ignored", busy, 0);

        // R6: clipped window at 0 (sigma > bound), zero threshold
        set_cfg(0, 0, 0, 3, 8, 0);
        launch(2);
        send(0, 5, 0);       // R7 drop 0 >= thr 0 -> 01
        send(11, 11, 0);     // R6 top end inclusive

        // random jobs
        for (int j = 0; j < 40; j++) begin
            int a, b, c, n;
            a = $urandom_range(300, 50);
            b = a + $urandom_range(200, 50);
            c = b + $urandom_range(300, 50);
            set_cfg(a, b, c, c + $urandom_range(4, 0) - 2, $urandom_range(60, 0),
                    $urandom_range(40, 0));
            n = $urandom_range(40, 1);
            launch(n);
            for (int k = 0; k < n; k++) begin
                int v1, v2;
                if ($urandom_range(1, 0) == 1)
                    v1 = cbd + $urandom_range(2 * csg + 4, 0) - csg - 2;
                else
                    v1 = $urandom_range(VMAX, 0);
                if (v1 < 0) v1 = 0;
                if (v1 > VMAX) v1 = VMAX;
                if ($urandom_range(7, 0) == 0) v2 = v1 + $urandom_range(20, 1);
                else v2 = v1 - $urandom_range(2 * cth + 2, 0);
                if (v2 < 0) v2 = 0;
                if (v2 > VMAX) v2 = VMAX;
                x = $urandom_range(2, 0);
                if (x == 2) set_cfg(1, 2, 3, 4, 5, 6); // R9 live change
                send(v1, v2, (x == 1) ? 1 : 0);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule